// File: doc/BRIEF.md
# HDLC Receive Deframer with Frame Check

This block turns a serial bit stream into checked frame payload. Bits arrive one per clock at most, qualified by a bit-valid strobe, and are looked at only while the enable input is high. The receiver hunts for the flag octet to fix the octet boundary. It then strips the zeros that a transmitter inserts after five ones. It assembles payload octets with the first received bit in bit 0, and hands each completed octet to the next stage as a one-cycle byte-write strobe with data.

The last two octets before the closing flag form the 16-bit frame check sequence. They are never forwarded: the block always holds back the two most recent octets of a frame, so it can drop them when the frame ends. A frame start and every frame end are reported as pulses with a 3-bit status code. The codes cover start detected, good frame, check failed, aborted and malformed. A downstream buffer can commit or discard the forwarded bytes from these codes.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While `enable` is 0, and on any cycle with `bitValid` 0, no input bit has an effect. Dropping `enable` abandons a frame in progress with no end pulse, and the receiver must see a flag again before it accepts a frame.
- R2: A flag is a 0, six 1s and a 0. It sets the octet boundary. Repeated flags and idle ones produce no output. The first full octet after a flag that is not itself a flag gives a `frameStart` pulse with status 3'b001.
- R3: Inside a frame, a 0 received right after five consecutive 1s is removed before octet assembly.
- R4: The first bit received of each octet lands in bit 0 of `byteData`.
- R5: Only de-stuffed octets between the opening and closing flags are forwarded on `byteValid`/`byteData`, in arrival order. The final two octets (the check sequence) are never forwarded. A frame with an empty information field forwards nothing.
- R6: The check is CRC-16 with polynomial x^16+x^12+x^5+1, processed least significant bit first, preset to all ones. A frame is good when the remainder over data and check octets is 16'hF0B8. A good frame ends with status 3'b010. A frame that fails the check ends with 3'b011, and its data octets are still forwarded.
- R7: Seven consecutive 1s inside a frame abort it: `frameEnd` pulses with status 3'b100 and the receiver hunts for a flag again. Octets forwarded before the abort stay forwarded. The two held-back octets are dropped.
- R8: A frame whose closing flag comes with fewer than two octets received, or not on an octet boundary, ends with status 3'b101.
- R9: `frameStatus` is 3'b000 whenever neither `frameStart` nor `frameEnd` pulses, and the two pulses never coincide.
- R10: Two frames that share a single flag (closing for the first, opening for the second) are both received in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Receiver enable; 0 holds it idle and hunting |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Serial line bit |
| byteValid | output | 1 | One-cycle strobe: `byteData` holds a payload octet |
| byteData | output | 8 | Payload octet, first received bit in bit 0 |
| frameStart | output | 1 | One-cycle pulse at the first payload octet of a frame |
| frameEnd | output | 1 | One-cycle pulse at the end of a frame |
| frameStatus | output | 3 | 001 start, 010 good, 011 check failed, 100 abort, 101 invalid, else 000 |

## Verification
Directed frames fix the bit order, using payloads such as 8'h01 against 8'h80. They also exercise stuffing, using all-ones octets and an embedded flag pattern that only pass through correctly if stuffed zeros are removed and not mistaken for flags. Edge frames cover each end code: an empty information field, a one-octet frame, a frame cut off the octet boundary, and aborts after zero, one and several octets, which show how many held-back octets survive. Shared-flag frames and a mid-frame enable drop tell correct resynchronisation apart from stale state. Random payloads of random length, some with a corrupted check sequence, are sent with random bit-valid gaps. They compare forwarded bytes and end codes against a reference check computed in the bench.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC  = 2'd1,
    ST_FRAME = 2'd2
  } rxState_e;

  // Strobes from the control path to the datapath, valid for one cycle.
  typedef struct packed {
    logic pushBit;     // a de-stuffed data bit enters the assembler
    logic octetDone;   // this bit completes an octet
    logic firstOctet;  // the completed octet is the first of a frame
    logic clearFrame;  // frame over: drop held-back octets
  } dpStrobe_t;

  localparam logic [2:0] STAT_NONE    = 3'b000;
  localparam logic [2:0] STAT_START   = 3'b001;
  localparam logic [2:0] STAT_GOOD    = 3'b010;
  localparam logic [2:0] STAT_FCSERR  = 3'b011;
  localparam logic [2:0] STAT_ABORT   = 3'b100;
  localparam logic [2:0] STAT_INVALID = 3'b101;

endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int OCTET_W    = 8,
  parameter int FCS_OCTETS = 2,
  parameter int STUFF_RUN  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       crcGood,
  output dpStrobe_t  strobe,
  output logic       frameStart,
  output logic       frameEnd,
  output logic [2:0] frameStatus
);

  localparam int RUN_W = $clog2(STUFF_RUN + 3);
  localparam int CNT_W = $clog2(OCTET_W);
  localparam int OCT_W = $clog2(FCS_OCTETS + 1);
  localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(STUFF_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(STUFF_RUN + 2);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OCTET_W - 1);
  localparam logic [OCT_W-1:0] OCT_MIN   = OCT_W'(FCS_OCTETS);

  rxState_e         state;
  logic [RUN_W-1:0] onesRun;
  logic [CNT_W-1:0] bitCnt;
  logic [OCT_W-1:0] octCnt;

  logic active, isStuff, isFlag, isAbort, isData, octetEdge;
  logic [2:0] endStatus;

  always_comb begin
    active    = enable && bitValid;
    isStuff   = active && !bitIn && (onesRun == RUN_STUFF);
    isFlag    = active && !bitIn && (onesRun == RUN_FLAG);
    isAbort   = active &&  bitIn && (onesRun == RUN_FLAG);
    isData    = active && (state != ST_HUNT) && !isStuff && !isFlag && !isAbort;
    octetEdge = isData && (bitCnt == CNT_LAST);

    strobe.pushBit    = isData;
    strobe.octetDone  = octetEdge;
    strobe.firstOctet = octetEdge && (state == ST_SYNC);
    strobe.clearFrame = (state == ST_FRAME) && (isFlag || isAbort);

    // The flag's leading 0 and six 1s were pushed as tentative data,
    // so an aligned frame closes with bitCnt at its last position.
    if ((bitCnt != CNT_LAST) || (octCnt < OCT_MIN)) endStatus = STAT_INVALID;
    else if (crcGood)                               endStatus = STAT_GOOD;
    else                                            endStatus = STAT_FCSERR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_HUNT;
      onesRun     <= '0;
      bitCnt      <= '0;
      octCnt      <= '0;
      frameStart  <= 1'b0;
      frameEnd    <= 1'b0;
      frameStatus <= STAT_NONE;
    end else begin
      frameStart  <= 1'b0;
      frameEnd    <= 1'b0;
      frameStatus <= STAT_NONE;
      if (!enable) begin
        state   <= ST_HUNT;
        onesRun <= '0;
        bitCnt  <= '0;
        octCnt  <= '0;
      end else if (bitValid) begin
        if (bitIn) onesRun <= (onesRun == RUN_MAX) ? onesRun : onesRun + RUN_W'(1);
        else       onesRun <= '0;
        if (isData) bitCnt <= (bitCnt == CNT_LAST) ? '0 : bitCnt + CNT_W'(1);
        unique case (state)
          ST_HUNT: begin
            if (isFlag) begin
              state  <= ST_SYNC;
              bitCnt <= '0;
              octCnt <= '0;
            end
          end
          ST_SYNC: begin
            if (isFlag) begin
              bitCnt <= '0;
            end else if (isAbort) begin
              state <= ST_HUNT;
            end else if (octetEdge) begin
              state       <= ST_FRAME;
              octCnt      <= OCT_W'(1);
              frameStart  <= 1'b1;
              frameStatus <= STAT_START;
            end
          end
          ST_FRAME: begin
            if (isFlag) begin
              state       <= ST_SYNC;
              bitCnt      <= '0;
              octCnt      <= '0;
              frameEnd    <= 1'b1;
              frameStatus <= endStatus;
            end else if (isAbort) begin
              state       <= ST_HUNT;
              bitCnt      <= '0;
              octCnt      <= '0;
              frameEnd    <= 1'b1;
              frameStatus <= STAT_ABORT;
            end else if (octetEdge && (octCnt != OCT_MIN)) begin
              octCnt <= octCnt + OCT_W'(1);
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  // R2: a frame start always carries the start code
  assert_start_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> frameStatus == STAT_START);

  // R9: status reads zero between events
  assert_idle_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frameStart || frameEnd) |-> frameStatus == STAT_NONE);

  // R9: start and end never pulse together
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frameStart && frameEnd));

  // R6 / R7 / R8: an end carries one of the four end codes
  assert_end_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frameEnd |-> (frameStatus == STAT_GOOD || frameStatus == STAT_FCSERR ||
                  frameStatus == STAT_ABORT || frameStatus == STAT_INVALID));

  // R1: a cycle with the receiver disabled produces no event after it
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !frameStart && !frameEnd);

  // R7: after an abort the receiver is hunting
  assert_abort_hunts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frameEnd && frameStatus == STAT_ABORT) |-> state == ST_HUNT);

endmodule

// File: rtl/hdlc_rx_datapath.sv
module hdlc_rx_datapath
  import hdlc_rx_pkg::*;
#(
  parameter int              OCTET_W    = 8,
  parameter int              CRC_W      = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD  = 16'hF0B8,
  parameter int              FCS_OCTETS = CRC_W / OCTET_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bitIn,
  input  dpStrobe_t          strobe,
  output logic               crcGood,
  output logic               byteValid,
  output logic [OCTET_W-1:0] byteData
);

  localparam int HELD_W = $clog2(FCS_OCTETS + 1);
  localparam logic [HELD_W-1:0] HELD_FULL = HELD_W'(FCS_OCTETS);

  logic [OCTET_W-1:0] shreg;
  logic [OCTET_W-1:0] assembled;
  logic [CRC_W-1:0]   crcReg, crcBase, crcNext;
  logic [HELD_W-1:0]  heldCnt;
  logic [OCTET_W-1:0] hold [FCS_OCTETS];

  // Reflected CRC over one octet, first received bit (bit 0) first.
  function automatic logic [CRC_W-1:0] crcAdvance(input logic [CRC_W-1:0] c,
                                                  input logic [OCTET_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < OCTET_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_comb begin
    assembled = {bitIn, shreg[OCTET_W-1:1]};
    crcBase   = strobe.firstOctet ? CRC_INIT : crcReg;
    crcNext   = crcAdvance(crcBase, assembled);
    crcGood   = (crcReg == CRC_GOOD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      crcReg    <= CRC_INIT;
      heldCnt   <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= 1'b0;
      if (strobe.pushBit) shreg <= assembled;
      if (strobe.clearFrame) heldCnt <= '0;
      if (strobe.octetDone) begin
        crcReg <= crcNext;
        if (strobe.firstOctet) begin
          heldCnt <= HELD_W'(1);
        end else if (heldCnt == HELD_FULL) begin
          byteValid <= 1'b1;
          byteData  <= hold[FCS_OCTETS-1];
        end else begin
          heldCnt <= heldCnt + HELD_W'(1);
        end
      end
    end
  end

  // Hold-back line: stage 0 is the newest octet, the last stage the oldest.
  always_ff @(posedge clk) begin
    if (!rst_n)                hold[0] <= '0;
    else if (strobe.octetDone) hold[0] <= assembled;
  end

  for (genvar s = 1; s < FCS_OCTETS; s++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)                hold[s] <= '0;
      else if (strobe.octetDone) hold[s] <= hold[s-1];
    end
  end

  // R5: a byte is only released by a completed octet
  assert_byte_needs_octet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid |-> $past(strobe.octetDone));

  // R5: the first octet of a frame is held back, never forwarded at once
  assert_first_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.firstOctet) |-> !byteValid);

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int               OCTET_W   = 8,
  parameter int               CRC_W     = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_GOOD  = 16'hF0B8,
  parameter int               STUFF_RUN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               bitValid,
  input  logic               bitIn,
  output logic               byteValid,
  output logic [OCTET_W-1:0] byteData,
  output logic               frameStart,
  output logic               frameEnd,
  output logic [2:0]         frameStatus
);

  localparam int FCS_OCTETS = CRC_W / OCTET_W;

  dpStrobe_t strobe;
  logic      crcGood;

  hdlc_rx_ctrl #(
    .OCTET_W    (OCTET_W),
    .FCS_OCTETS (FCS_OCTETS),
    .STUFF_RUN  (STUFF_RUN)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .bitValid    (bitValid),
    .bitIn       (bitIn),
    .crcGood     (crcGood),
    .strobe      (strobe),
    .frameStart  (frameStart),
    .frameEnd    (frameEnd),
    .frameStatus (frameStatus)
  );

  hdlc_rx_datapath #(
    .OCTET_W    (OCTET_W),
    .CRC_W      (CRC_W),
    .CRC_POLY   (CRC_POLY),
    .CRC_INIT   (CRC_INIT),
    .CRC_GOOD   (CRC_GOOD),
    .FCS_OCTETS (FCS_OCTETS)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bitIn     (bitIn),
    .strobe    (strobe),
    .crcGood   (crcGood),
    .byteValid (byteValid),
    .byteData  (byteData)
  );

endmodule

// File: tb/hdlc_rx_deframer_tb_top.sv
module hdlc_rx_deframer_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  typedef logic [7:0] octQ_t[$];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic       byteValid;
  logic [7:0] byteData;
  logic       frameStart;
  logic       frameEnd;
  logic [2:0] frameStatus;

  always #2.5 clk = ~clk;

  hdlc_rx_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bitValid(bitValid), .bitIn(bitIn),
    .byteValid(byteValid), .byteData(byteData), .frameStart(frameStart),
    .frameEnd(frameEnd), .frameStatus(frameStatus)
  );

  int total = 0;
  int bad = 0;
  int startCnt = 0;
  int startBadCode = 0;
  int idleBad = 0;
  int txOnes = 0;
  bit gapOn = 0;
  logic [7:0] rxQ[$];
  logic [2:0] endQ[$];

  // Output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (byteValid) rxQ.push_back(byteData);
      if (frameStart) begin
        startCnt++;
        if (frameStatus != 3'b001) startBadCode++;
      end
      if (frameEnd) endQ.push_back(frameStatus);
      if (!frameStart && !frameEnd && frameStatus != 3'b000) idleBad++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkBytes(input string req, input octQ_t exp);
    int firstBad = -1;
    if (rxQ.size() != exp.size()) begin
      check(0, req, "byte count", rxQ.size(), exp.size());
      return;
    end
    foreach (exp[i]) if (firstBad < 0 && rxQ[i] !== exp[i]) firstBad = i;
    if (firstBad < 0) check(1, req, "bytes", 0, 0);
    else check(0, req, "byte value", int'(rxQ[firstBad]), int'(exp[firstBad]));
  endtask

  task automatic clearRx();
    rxQ.delete();
    endQ.delete();
    startCnt = 0;
  endtask

  function automatic logic [15:0] fcsOf(input octQ_t d);
    logic [15:0] c = 16'hFFFF;
    foreach (d[k]) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ d[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return ~c;
  endfunction

  task automatic sendBit(input logic b);
    if (gapOn && ($urandom % 4 == 0)) begin
      bitValid = 1'b0;
      bitIn = 1'($urandom);
      @(negedge clk);
    end
    bitValid = 1'b1;
    bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic sendData(input logic b);
    sendBit(b);
    if (b) begin
      txOnes++;
      if (txOnes == 5) begin
        sendBit(1'b0);
        txOnes = 0;
      end
    end else txOnes = 0;
  endtask

  task automatic sendOctet(input logic [7:0] o);
    for (int i = 0; i < 8; i++) sendData(o[i]);
  endtask

  task automatic sendFlag();
    logic [7:0] f = 8'h7E;
    for (int i = 0; i < 8; i++) sendBit(f[i]);
    txOnes = 0;
  endtask

  task automatic sendBody(input octQ_t d, input bit badFcs);
    logic [15:0] f = fcsOf(d);
    if (badFcs) f = f ^ 16'h0100;
    foreach (d[k]) sendOctet(d[k]);
    sendOctet(f[7:0]);
    sendOctet(f[15:8]);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic runFrame(input string req, input octQ_t d, input bit badFcs);
    clearRx();
    sendFlag();
    sendBody(d, badFcs);
    sendFlag();
    settle();
    check(startCnt == 1, req, "start count", startCnt, 1);
    check(endQ.size() == 1 && endQ[0] == (badFcs ? 3'b011 : 3'b010), req, "end code",
          endQ.size() > 0 ? int'(endQ[0]) : -1, badFcs ? 3 : 2);
    checkBytes(req, d);
  endtask

  // Abort after n data octets: one extra 0, then eight 1s.
  task automatic runAbort(input string req, input octQ_t d);
    octQ_t keep;
    clearRx();
    sendFlag();
    foreach (d[k]) sendOctet(d[k]);
    sendData(1'b0);
    for (int i = 0; i < 8; i++) sendBit(1'b1);
    txOnes = 0;
    sendFlag();
    sendFlag();
    settle();
    for (int i = 0; i + 2 < d.size(); i++) keep.push_back(d[i]);
    if (d.size() == 0) begin
      check(startCnt == 0 && endQ.size() == 0, req, "abort without octet events",
            startCnt + endQ.size(), 0);
    end else begin
      check(startCnt == 1, req, "abort start count", startCnt, 1);
      check(endQ.size() == 1 && endQ[0] == 3'b100, req, "abort end code",
            endQ.size() > 0 ? int'(endQ[0]) : -1, 4);
      checkBytes(req, keep);
    end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    octQ_t d;
    octQ_t a;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(!byteValid && !frameStart && !frameEnd && frameStatus == 3'b000, "R9",
          "reset outputs", {byteValid, frameStart, frameEnd, frameStatus}, 0);

    // R1: a full frame while disabled has no effect
    clearRx();
    sendFlag();
    sendBody('{8'h11, 8'h22, 8'h33}, 0);
    sendFlag();
    settle();
    check(startCnt == 0 && endQ.size() == 0 && rxQ.size() == 0, "R1", "disabled activity",
          startCnt + endQ.size() + rxQ.size(), 0);

    enable = 1'b1;
    // R2: idle ones and repeated flags give no events
    clearRx();
    for (int i = 0; i < 20; i++) sendBit(1'b1);
    repeat (3) sendFlag();
    settle();
    check(startCnt == 0 && endQ.size() == 0 && rxQ.size() == 0, "R2", "idle/flags silent",
          startCnt + endQ.size() + rxQ.size(), 0);

    // R4: bit order
    runFrame("R4", '{8'h01, 8'h80, 8'hA5}, 0);
    // R3: stuffing inside data, including a flag pattern
    runFrame("R3", '{8'hFF, 8'h7E, 8'hFC, 8'h3F, 8'hFF}, 0);
    // R5: empty information field
    runFrame("R5", '{}, 0);
    // R6: corrupted check sequence
    runFrame("R6", '{8'h12, 8'h34, 8'h56}, 1);

    // R8: too short
    clearRx();
    sendFlag();
    sendOctet(8'h5A);
    sendFlag();
    settle();
    check(startCnt == 1 && endQ.size() == 1 && endQ[0] == 3'b101, "R8", "short frame code",
          endQ.size() > 0 ? int'(endQ[0]) : -1, 5);
    check(rxQ.size() == 0, "R8", "short frame bytes", rxQ.size(), 0);

    // R8: off the octet boundary
    clearRx();
    sendFlag();
    sendBody('{8'h33, 8'h44}, 0);
    sendData(1'b1); sendData(1'b0); sendData(1'b1);
    sendFlag();
    settle();
    check(endQ.size() == 1 && endQ[0] == 3'b101, "R8", "misaligned code",
          endQ.size() > 0 ? int'(endQ[0]) : -1, 5);

    // R7: aborts after zero, one and five octets
    runAbort("R7", '{});
    runAbort("R7", '{8'hC3});
    runAbort("R7", '{8'h01, 8'h02, 8'h03, 8'hF8, 8'h1F});

    // R10: two frames sharing one flag
    clearRx();
    a = '{8'hDE, 8'hAD};
    d = '{8'hBE, 8'hEF, 8'h00};
    sendFlag();
    sendBody(a, 0);
    sendFlag();
    sendBody(d, 0);
    sendFlag();
    settle();
    check(startCnt == 2, "R10", "shared flag starts", startCnt, 2);
    check(endQ.size() == 2 && endQ[0] == 3'b010 && endQ[1] == 3'b010, "R10",
          "shared flag ends", endQ.size(), 2);
    checkBytes("R10", '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00});

    // R1: enable dropped mid-frame abandons it silently
    clearRx();
    sendFlag();
    sendOctet(8'h11);
    sendOctet(8'h22);
    enable = 1'b0;
    repeat (6) @(negedge clk);
    enable = 1'b1;
    txOnes = 0;
    sendOctet(8'h99);
    sendFlag();
    sendBody('{8'hC3}, 0);
    sendFlag();
    settle();
    check(startCnt == 2, "R1", "starts around enable drop", startCnt, 2);
    check(endQ.size() == 1 && endQ[0] == 3'b010, "R1", "single end after drop",
          endQ.size(), 1);
    checkBytes("R1", '{8'hC3});

    // Random frames with bit-valid gaps
    gapOn = 1;
    for (int n = 0; n < 30; n++) begin
      octQ_t r;
      int len = $urandom_range(0, 24);
      bit corrupt = ($urandom % 5 == 0);
      for (int i = 0; i < len; i++) r.push_back(8'($urandom));
      runFrame(corrupt ? "R6" : "R5", r, corrupt);
    end
    for (int n = 0; n < 6; n++) begin
      octQ_t r;
      int len = $urandom_range(1, 10);
      for (int i = 0; i < len; i++) r.push_back(8'($urandom));
      runAbort("R7", r);
    end
    gapOn = 0;

    check(startBadCode == 0, "R2", "start code", startBadCode, 0);
    check(idleBad == 0, "R9", "idle status nonzero", idleBad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule